// File: doc/BRIEF.md
# Multi-Port Packet Readout to AXI4-Stream

This block turns queued packet descriptors into framed AXI4-Stream packets. Each descriptor names a source port, a start word address inside that port's buffer, and a length in bytes. The block takes one descriptor and puts a generated header word on the stream. It then reads the packet's payload words from the named port buffer and sends them in order. It marks the final beat with TLAST and trims that beat's TKEEP to the exact byte count.

The port buffers are held inside the block as synchronous-read memories, one per port, all filled through a single write port. The buffers are circular, so a packet that runs past the last word continues from word zero. Only one packet is in flight at a time. The next descriptor is taken only after the previous packet's TLAST beat has been accepted downstream. Under TREADY backpressure the stream holds its beat unchanged. When TREADY stays high, the block delivers one beat per cycle.

Top module: `pkt_readout_axis`

## Requirements
- R1: The first beat of every packet is a header word: source port index in TDATA[31:28], zero in TDATA[27:16], byte length in TDATA[15:0], and TKEEP = 4'b1111.
- R2: After the header come ceil(len/4) payload beats. Beat i carries the word stored at address (start + i) of the named port's buffer.
- R3: Payload addresses wrap modulo the buffer depth (2^ADDR_W words), so a packet may run past the last word and continue from address 0.
- R4: Every beat except the last has TKEEP = 4'b1111. The last payload beat has TKEEP set by len mod 4: 1 gives 4'b0001, 2 gives 4'b0011, 3 gives 4'b0111, and 0 gives 4'b1111. Byte lane 0 is TDATA[7:0].
- R5: TLAST is 1 only on the last beat of a packet. A zero-length packet is the header alone, with TLAST = 1.
- R6: While TVALID is 1 and TREADY is 0, the next cycle still has TVALID = 1 with TDATA, TKEEP and TLAST unchanged.
- R7: A descriptor is accepted (desc_valid and desc_ready both 1) only when no packet is in flight. desc_ready is 0 from the acceptance cycle until the cycle after the TLAST handshake.
- R8: After reset, TVALID is 0 and desc_ready is 1.
- R9: A write with wr_en = 1 stores wr_data at wr_addr in the buffer of port wr_port only. Later packets read that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_port | input | PORT_W | Port whose buffer is written |
| wr_addr | input | ADDR_W | Word address written |
| wr_data | input | 32 | Word written |
| desc_valid | input | 1 | Descriptor available from the header queue |
| desc_ready | output | 1 | Descriptor taken (pop) when high with desc_valid |
| desc_port | input | PORT_W | Source port of the packet |
| desc_addr | input | ADDR_W | Start word address in that port's buffer |
| desc_len | input | 16 | Packet length in bytes |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 32 | Stream data |
| m_tkeep | output | 4 | Byte enables, bit k for TDATA[8k+7:8k] |
| m_tlast | output | 1 | Last beat of packet |

## Verification
The bench builds the block with NUM_PORTS = 4 and ADDR_W = 4, which gives 16-word buffers. With buffers this small, packets that wrap, packets that fill a whole buffer and packets longer than a buffer all fit into a few hundred cycles. Four ports fill the header's port field with indices 0 to 3. The bench exercises lengths 0 to 7, so every TKEEP residue appears on the final beat. It runs these packets under an always-ready sink, a random sink and a mostly-stalled sink. It also overwrites one port's words between packets to show that a write lands in that port's buffer only.

// File: rtl/pkt_rd_pkg.sv
package pkt_rd_pkg;
  localparam int DATA_W = 32;
  localparam int KEEP_W = DATA_W / 8;
  localparam int LEN_W  = 16;

  // number of payload beats for a byte length (ceiling of len/4)
  function automatic logic [LEN_W-1:0] beat_count(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] t;
    t = {1'b0, len} + (LEN_W+1)'(KEEP_W - 1);
    return LEN_W'(t >> 2);
  endfunction

  // byte enables of the final payload beat
  function automatic logic [KEEP_W-1:0] last_keep(input logic [LEN_W-1:0] len);
    case (len[1:0])
      2'd1:    return 4'b0001;
      2'd2:    return 4'b0011;
      2'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  // header word: port in [31:28], byte length in [15:0]
  function automatic logic [DATA_W-1:0] make_header(input logic [3:0] port,
                                                    input logic [LEN_W-1:0] len);
    return {port, 12'h000, len};
  endfunction
endpackage

// File: rtl/pkt_port_bufs.sv
module pkt_port_bufs
  import pkt_rd_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] port_q [NUM_PORTS];
  logic [PORT_W-1:0] sel_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [DATA_W-1:0] mem [DEPTH];
    logic wr_hit, rd_hit;
    assign wr_hit = wr_en && (wr_port == PORT_W'(p));
    assign rd_hit = rd_en && (rd_port == PORT_W'(p));

    always_ff @(posedge clk) begin
      if (wr_hit) mem[wr_addr] <= wr_data;
      if (rd_hit) port_q[p] <= mem[rd_addr];
    end
  end

  // select register follows the last read so the word stays put until the next one
  always_ff @(posedge clk) begin
    if (rd_en) sel_q <= rd_port;
  end

  assign rd_data = port_q[sel_q];
endmodule

// File: rtl/pkt_rd_ctrl.sv
module pkt_rd_ctrl
  import pkt_rd_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  input  logic [PORT_W-1:0] desc_port,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  desc_len,
  output logic              desc_ready,
  input  logic              q_take,
  input  logic              pkt_done,
  output logic              rd_en,
  output logic [PORT_W-1:0] rd_port,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              q_valid,
  output logic              hdr_load,
  output logic [DATA_W-1:0] hdr_word,
  output logic              hdr_last,
  output logic              data_last,
  output logic [KEEP_W-1:0] data_keep
);
  function automatic logic [ADDR_W-1:0] wrap_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic              busy;
  logic [PORT_W-1:0] cur_port;
  logic [ADDR_W-1:0] nxt_addr;
  logic [LEN_W-1:0]  rd_left;
  logic [LEN_W-1:0]  out_left;
  logic [KEEP_W-1:0] keep_last;
  logic [LEN_W-1:0]  desc_beats;
  logic              accept;
  logic              rd_more;

  assign desc_ready = !busy;
  assign accept     = desc_valid && !busy;
  assign desc_beats = beat_count(desc_len);
  assign rd_more    = busy && (rd_left != '0) && (!q_valid || q_take);
  assign rd_en      = (accept && (desc_beats != '0)) || rd_more;
  assign rd_port    = accept ? desc_port : cur_port;
  assign rd_addr    = accept ? desc_addr : nxt_addr;

  assign hdr_load   = accept;
  assign hdr_word   = make_header(4'(desc_port), desc_len);
  assign hdr_last   = (desc_len == '0);
  assign data_last  = (out_left == LEN_W'(1));
  assign data_keep  = data_last ? keep_last : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_port  <= '0;
      nxt_addr  <= '0;
      rd_left   <= '0;
      out_left  <= '0;
      keep_last <= '1;
      q_valid   <= 1'b0;
    end else begin
      if (accept) begin
        busy      <= 1'b1;
        cur_port  <= desc_port;
        nxt_addr  <= wrap_inc(desc_addr);
        rd_left   <= (desc_beats != '0) ? desc_beats - LEN_W'(1) : '0;
        out_left  <= desc_beats;
        keep_last <= last_keep(desc_len);
      end else begin
        if (rd_more) begin
          nxt_addr <= wrap_inc(nxt_addr);
          rd_left  <= rd_left - LEN_W'(1);
        end
        if (q_take)   out_left <= out_left - LEN_W'(1);
        if (pkt_done) busy     <= 1'b0;
      end
      if (rd_en)       q_valid <= 1'b1;
      else if (q_take) q_valid <= 1'b0;
    end
  end

  AST_TAKE_WITHIN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    q_take |-> (busy && out_left != '0)); // R2
  AST_READS_NOT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_left <= out_left)); // R2
endmodule

// File: rtl/pkt_axis_stage.sv
module pkt_axis_stage
  import pkt_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_load,
  input  logic [DATA_W-1:0] hdr_word,
  input  logic              hdr_last,
  input  logic              q_valid,
  input  logic [DATA_W-1:0] q_word,
  input  logic              data_last,
  input  logic [KEEP_W-1:0] data_keep,
  input  logic              m_tready,
  output logic              m_tvalid,
  output logic [DATA_W-1:0] m_tdata,
  output logic [KEEP_W-1:0] m_tkeep,
  output logic              m_tlast,
  output logic              q_take,
  output logic              pkt_done
);
  assign q_take   = q_valid && !hdr_load && (!m_tvalid || m_tready);
  assign pkt_done = m_tvalid && m_tready && m_tlast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tkeep  <= '0;
      m_tlast  <= 1'b0;
    end else if (hdr_load) begin
      m_tvalid <= 1'b1;
      m_tdata  <= hdr_word;
      m_tkeep  <= '1;
      m_tlast  <= hdr_last;
    end else if (q_take) begin
      m_tvalid <= 1'b1;
      m_tdata  <= q_word;
      m_tkeep  <= data_keep;
      m_tlast  <= data_last;
    end else if (m_tready) begin
      m_tvalid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast))); // R6
  AST_KEEP_FULL_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tlast) |-> (m_tkeep == 4'b1111)); // R4
  AST_KEEP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tkeep inside {4'b0001, 4'b0011, 4'b0111, 4'b1111})); // R4
  AST_HDR_INTO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_load |-> !m_tvalid); // R7
endmodule

// File: rtl/pkt_readout_axis.sv
module pkt_readout_axis
  import pkt_rd_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [PORT_W-1:0] desc_port,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [15:0]       desc_len,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [31:0]       m_tdata,
  output logic [3:0]        m_tkeep,
  output logic              m_tlast
);
  logic              rd_en;
  logic [PORT_W-1:0] rd_port;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic              q_valid, q_take, pkt_done;
  logic              hdr_load, hdr_last, data_last;
  logic [DATA_W-1:0] hdr_word;
  logic [KEEP_W-1:0] data_keep;

  pkt_port_bufs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_bufs (
    .clk(clk), .wr_en(wr_en), .wr_port(wr_port), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_port(rd_port), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  pkt_rd_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_port(desc_port), .desc_addr(desc_addr), .desc_len(desc_len),
    .desc_ready(desc_ready), .q_take(q_take), .pkt_done(pkt_done),
    .rd_en(rd_en), .rd_port(rd_port), .rd_addr(rd_addr), .q_valid(q_valid),
    .hdr_load(hdr_load), .hdr_word(hdr_word), .hdr_last(hdr_last),
    .data_last(data_last), .data_keep(data_keep)
  );

  pkt_axis_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .hdr_load(hdr_load), .hdr_word(hdr_word), .hdr_last(hdr_last),
    .q_valid(q_valid), .q_word(rd_data), .data_last(data_last), .data_keep(data_keep),
    .m_tready(m_tready), .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tlast(m_tlast), .q_take(q_take), .pkt_done(pkt_done)
  );

  AST_NO_POP_MID_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !(m_tready && m_tlast)) |-> !desc_ready); // R7
  AST_QWORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_take) |=> (q_valid && $stable(rd_data))); // R2
  AST_HDR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_load |=> (m_tdata[15:0] == $past(desc_len) && m_tdata[31:28] == 4'($past(desc_port))
                  && m_tdata[27:16] == 12'h000 && m_tkeep == 4'b1111)); // R1
  AST_ZERO_LEN_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_load && desc_len == 16'd0) |=> m_tlast); // R5
endmodule

// File: tb/tb_pkt_readout_axis.sv
module tb_pkt_readout_axis;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_port = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic desc_valid = 1'b0, desc_ready;
  logic [1:0] desc_port = '0;
  logic [AW-1:0] desc_addr = '0;
  logic [15:0] desc_len = '0;
  logic m_tvalid, m_tready = 1'b1, m_tlast;
  logic [31:0] m_tdata;
  logic [3:0] m_tkeep;

  pkt_readout_axis #(.NUM_PORTS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port), .wr_addr(wr_addr),
    .wr_data(wr_data), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_port(desc_port), .desc_addr(desc_addr), .desc_len(desc_len),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
    .m_tlast(m_tlast)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  logic [31:0] mirror [NP][DEPTH];
  logic [31:0] exp_d [$];
  logic [3:0]  exp_k [$];
  logic        exp_l [$];
  string       exp_r [$];
  bit in_pkt = 0, prev_stall = 0, started = 0;
  logic [31:0] prev_d;
  logic [3:0]  prev_k;
  logic        prev_l;
  int rmode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // reference: beats expected for one accepted descriptor
  task automatic push_expected(int p, int a, int len);
    int beats;
    logic [3:0] lk;
    beats = (len + 3) / 4;
    case (len % 4)
      1: lk = 4'b0001;
      2: lk = 4'b0011;
      3: lk = 4'b0111;
      default: lk = 4'b1111;
    endcase
    exp_d.push_back({4'(p), 12'h000, 16'(len)});
    exp_k.push_back(4'b1111);
    exp_l.push_back(beats == 0);
    exp_r.push_back("R1");
    for (int i = 0; i < beats; i++) begin
      exp_d.push_back(mirror[p][(a + i) % DEPTH]);
      exp_k.push_back((i == beats - 1) ? lk : 4'b1111);
      exp_l.push_back(i == beats - 1);
      exp_r.push_back((a + i >= DEPTH) ? "R3" : "R2,R9");
    end
  endtask

  // sink pattern: 0 always ready, 1 random, 2 mostly stalled
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rmode)
      0: m_tready = 1'b1;
      1: m_tready = lfsr[0];
      default: m_tready = (lfsr[2:0] == 3'd0);
    endcase
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (started) begin
      if (prev_stall)
        chk(m_tvalid && m_tdata == prev_d && m_tkeep == prev_k && m_tlast == prev_l,
            "R6", "beat changed under stall", m_tdata, prev_d);
      if (desc_valid && desc_ready) begin
        chk(!in_pkt, "R7", "descriptor popped mid packet", 32'(in_pkt), 32'd0);
        in_pkt = 1;
        push_expected(int'(desc_port), int'(desc_addr), int'(desc_len));
      end
      if (m_tvalid && m_tready) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R5", "beat beyond packet end", m_tdata, 32'd0);
        end else begin
          logic [31:0] ed;
          logic [3:0] ek;
          logic el;
          string er;
          ed = exp_d.pop_front(); ek = exp_k.pop_front();
          el = exp_l.pop_front(); er = exp_r.pop_front();
          chk(m_tdata == ed, er, "tdata", m_tdata, ed);
          chk(m_tkeep == ek, "R4", "tkeep", 32'(m_tkeep), 32'(ek));
          chk(m_tlast == el, "R5", "tlast", 32'(m_tlast), 32'(el));
        end
        if (m_tlast) in_pkt = 0;
      end
      prev_stall = m_tvalid && !m_tready;
      prev_d = m_tdata; prev_k = m_tkeep; prev_l = m_tlast;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", exp_d.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // R9 writes through the buffer port, mirrored in the bench
  task automatic wr_word(int p, int a, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_port = 2'(p); wr_addr = AW'(a); wr_data = d;
    mirror[p][a] = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic send_desc(int p, int a, int len);
    @(posedge clk); #1;
    desc_valid = 1'b1; desc_port = 2'(p); desc_addr = AW'(a); desc_len = 16'(len);
    @(negedge clk);
    while (!desc_ready) @(negedge clk);
    @(posedge clk); #1;
    desc_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (in_pkt || exp_d.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_tvalid == 1'b0, "R8", "tvalid in reset", 32'(m_tvalid), 32'd0);
    chk(desc_ready == 1'b1, "R8", "desc_ready in reset", 32'(desc_ready), 32'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_tvalid == 1'b0, "R8", "tvalid after reset", 32'(m_tvalid), 32'd0);
    chk(desc_ready == 1'b1, "R8", "desc_ready after reset", 32'(desc_ready), 32'd1);
    started = 1;

    for (int p = 0; p < NP; p++)
      for (int a = 0; a < DEPTH; a++)
        wr_word(p, a, {4'(p + 1), 4'(a), 8'(a * 7 + p), 16'(a * 16'h1357 + p * 16'h0F0F)});

    // every residue of len mod 4, always-ready sink
    rmode = 0;
    for (int len = 0; len < 8; len++) send_desc(len % NP, len, len);
    wait_idle();

    // wrap-around, full buffer and longer than one buffer (R3)
    send_desc(2, 14, 12);
    send_desc(3, 15, 64);
    send_desc(1, 9, 70);
    wait_idle();

    // R9: rewrite port 1 only, then read both port 1 and port 0 at the same addresses
    for (int a = 0; a < 4; a++) wr_word(1, a, 32'hD00D_0000 + 32'(a));
    send_desc(1, 0, 16);
    send_desc(0, 0, 16);
    wait_idle();

    // random backpressure, back to back (R6, R7)
    rmode = 1;
    for (int k = 0; k < 12; k++) send_desc(k % NP, (k * 5) % DEPTH, (k * 7) % 23);
    wait_idle();

    // mostly stalled sink
    rmode = 2;
    send_desc(3, 13, 13);
    send_desc(0, 6, 0);
    send_desc(2, 1, 9);
    wait_idle();
    rmode = 0;

    chk(exp_d.size() == 0, "R2", "beats still outstanding", 32'(exp_d.size()), 32'd0);
    chk(m_tvalid == 1'b0 && desc_ready == 1'b1, "R7", "idle at end",
        {30'd0, m_tvalid, desc_ready}, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule